// File: doc/BRIEF.md
# Boolean Decomposition Stage Sequencer

This controller steers a chain of five hardware stages that together decompose a Boolean function. The board is reconfigured between stages. When the host raises `sys_start_i`, the controller copies a header and a list of product terms from an input FIFO into memory bank A. It then launches each stage in a fixed order:

- variable partitioning,
- compatibility graph,
- maximum clique,
- G-function generation,
- H-function generation.

Between two stages the controller hands control back to the host, which reprograms the board. The controller waits for the host to report that the board is ready before it starts the next stage. When the last stage reports completion, the controller raises `sys_done_o`.

The stage datapaths, the memory banks and the result FIFO lie outside this block. The controller only issues strobes and addresses, and it observes the one-cycle completion pulses.

The FIFO is a show-ahead FIFO: the word at its head is present on `fifo_data_i` whenever `fifo_empty_i` is low. Asserting `fifo_rd_o` consumes that word at the next clock edge.

Top module: `decomp_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, every output is low: `fifo_rd_o`, `bank_a_we_o`, `stage_start_o`, `next_stage_o` and `sys_done_o`.
- R2: A load begins in the cycle after `sys_start_i` is seen high while the block is idle or done. The first FIFO word (the variable count) is written to bank A address 0. The second FIFO word (the term count m) is written to address 1 and kept for the loop bound.
- R3: Product term number C (counting from 1) is written to bank A address C+1. The load ends with the write of term m, so exactly m+2 words are written. When m = 0, the load ends after the header.
- R4: `fifo_rd_o` is high only in a load cycle in which `fifo_empty_i` is low. `bank_a_we_o` is high in exactly those cycles, with `bank_a_wdata_o` equal to `fifo_data_i` in that cycle. An empty FIFO stalls the load without losing or repeating a word.
- R5: Stage starts are single-cycle pulses, at most one bit high at a time. Bit index is stage order: bit 0 variable partitioning, bit 1 compatibility graph, bit 2 maximum clique, bit 3 G-function, bit 4 H-function. The stages are launched strictly in that order.
- R6: The bit 0 start pulse appears in the cycle right after the cycle of the final load write, with no host handshake before it.
- R7: After each stage except the last reports done, `next_stage_o` rises in the next cycle and stays high until `board_ready_i` is seen. The next stage's start pulse appears in the cycle after `board_ready_i` is seen.
- R8: While a stage runs, only that stage's own `stage_done_i` bit ends it. Done pulses on other bits, and `board_ready_i` outside a handoff, have no effect.
- R9: `sys_done_o` rises in the cycle after the last stage's done pulse and stays high until a new `sys_start_i`. A `sys_start_i` seen while a load or stage sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_start_i | input | 1 | Host request to begin a run |
| sys_done_o | output | 1 | Run complete, held until next start |
| fifo_empty_i | input | 1 | Input FIFO has no word available |
| fifo_data_i | input | DATA_W | Word at the head of the input FIFO |
| fifo_rd_o | output | 1 | Consume the head word at this edge |
| bank_a_we_o | output | 1 | Bank A write strobe |
| bank_a_addr_o | output | ADDR_W | Bank A write address |
| bank_a_wdata_o | output | DATA_W | Bank A write data |
| stage_start_o | output | NUM_STAGES | One-cycle launch pulse per stage |
| stage_done_i | input | NUM_STAGES | One-cycle completion pulse per stage |
| next_stage_o | output | 1 | Request to the host to reprogram the board |
| board_ready_i | input | 1 | Host reports the board is reprogrammed |

## Verification
The bench starves the loader by withholding the FIFO mid-header and mid-terms. A loader that reads an empty FIFO would write garbage or skip a term. One that advanced its counter on a stall would leave a hole in bank A.

It runs term counts of 0, 1 and several words. An off-by-one loop bound would either stop one term early, swallow a word meant for a later run, or never leave the load when m is zero.

It fires done pulses for stages that are not running, stray ready strobes and repeated start requests mid-run. A controller that watched the wrong done bit, or restarted on a late start, would skip stages or clear its result early. Zero-latency stage and host responses check that no cycle is lost at any handshake.

// File: rtl/decomp_seq_pkg.sv
package decomp_seq_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_START = 2'd1,
      CH_WAIT  = 2'd2,
      CH_HAND  = 2'd3
   } chain_state_e;

   function automatic int sel_width(int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dsc_loader.sv
module dsc_loader #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              fifo_empty_i,
   input  logic [DATA_W-1:0] fifo_data_i,
   output logic              fifo_rd_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              last_o
);
   localparam int CNT_W = (DATA_W + 1 > ADDR_W) ? DATA_W + 1 : ADDR_W;

   logic              active_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] terms_q;
   logic              take;
   logic              at_count_word;
   logic              last_w;

   assign take          = active_q && !fifo_empty_i;
   assign at_count_word = (cnt_q == CNT_W'(1));

   // word 1 carries the term count; a zero count ends the load right there
   always_comb begin
      if (at_count_word)
         last_w = take && (fifo_data_i == '0);
      else
         last_w = take && (cnt_q >= CNT_W'(2)) &&
                  (cnt_q == CNT_W'(terms_q) + CNT_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         terms_q  <= '0;
      end else if (go_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (take) begin
         if (at_count_word)
            terms_q <= fifo_data_i;
         if (last_w)
            active_q <= 1'b0;
         else
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign fifo_rd_o = take;
   assign wr_en_o   = take;
   assign wr_addr_o = cnt_q[ADDR_W-1:0];
   assign wr_data_o = fifo_data_i;
   assign busy_o    = active_q;
   assign last_o    = last_w;

endmodule

// File: rtl/dsc_stage_chain.sv
module dsc_stage_chain
   import decomp_seq_pkg::*;
#(
   parameter int NUM_STAGES = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go_i,
   input  logic [NUM_STAGES-1:0] stage_done_i,
   input  logic                  board_ready_i,
   output logic [NUM_STAGES-1:0] stage_start_o,
   output logic                  next_stage_o,
   output logic                  finish_o,
   output logic                  busy_o
);
   localparam int SEL_W = sel_width(NUM_STAGES);
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_STAGES - 1);

   chain_state_e          st_q;
   logic [SEL_W-1:0]      sel_q;
   logic [NUM_STAGES-1:0] sel_hot;
   logic                  cur_done;
   logic                  at_last;

   for (genvar g = 0; g < NUM_STAGES; g++) begin : g_sel
      assign sel_hot[g] = (sel_q == SEL_W'(g));
   end

   assign cur_done = |(stage_done_i & sel_hot);
   assign at_last  = (sel_q == LAST_SEL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= CH_IDLE;
         sel_q <= '0;
      end else begin
         case (st_q)
            CH_IDLE: if (go_i) begin
               st_q  <= CH_START;
               sel_q <= '0;
            end
            CH_START: st_q <= CH_WAIT;
            CH_WAIT: if (cur_done)
               st_q <= at_last ? CH_IDLE : CH_HAND;
            CH_HAND: if (board_ready_i) begin
               sel_q <= sel_q + SEL_W'(1);
               st_q  <= CH_START;
            end
            default: st_q <= CH_IDLE;
         endcase
      end
   end

   assign stage_start_o = (st_q == CH_START) ? sel_hot : '0;
   assign next_stage_o  = (st_q == CH_HAND);
   assign finish_o      = (st_q == CH_WAIT) && cur_done && at_last;
   assign busy_o        = (st_q != CH_IDLE);

endmodule

// File: rtl/decomp_seq_ctrl.sv
module decomp_seq_ctrl #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 10,
   parameter int NUM_STAGES = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sys_start_i,
   output logic                  sys_done_o,
   input  logic                  fifo_empty_i,
   input  logic [DATA_W-1:0]     fifo_data_i,
   output logic                  fifo_rd_o,
   output logic                  bank_a_we_o,
   output logic [ADDR_W-1:0]     bank_a_addr_o,
   output logic [DATA_W-1:0]     bank_a_wdata_o,
   output logic [NUM_STAGES-1:0] stage_start_o,
   input  logic [NUM_STAGES-1:0] stage_done_i,
   output logic                  next_stage_o,
   input  logic                  board_ready_i
);
   if (DATA_W < 1) begin : g_bad_data
      $error("decomp_seq_ctrl: DATA_W must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("decomp_seq_ctrl: ADDR_W must hold the two header addresses");
   end
   if (NUM_STAGES < 1) begin : g_bad_stages
      $error("decomp_seq_ctrl: NUM_STAGES must be at least 1");
   end

   logic load_busy;
   logic load_last;
   logic chain_busy;
   logic chain_finish;
   logic run_go;
   logic done_q;

   assign run_go = sys_start_i && !load_busy && !chain_busy;

   dsc_loader #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) loader_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_i         (run_go),
      .fifo_empty_i (fifo_empty_i),
      .fifo_data_i  (fifo_data_i),
      .fifo_rd_o    (fifo_rd_o),
      .wr_en_o      (bank_a_we_o),
      .wr_addr_o    (bank_a_addr_o),
      .wr_data_o    (bank_a_wdata_o),
      .busy_o       (load_busy),
      .last_o       (load_last)
   );

   dsc_stage_chain #(
      .NUM_STAGES (NUM_STAGES)
   ) chain_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .go_i          (load_last),
      .stage_done_i  (stage_done_i),
      .board_ready_i (board_ready_i),
      .stage_start_o (stage_start_o),
      .next_stage_o  (next_stage_o),
      .finish_o      (chain_finish),
      .busy_o        (chain_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         done_q <= 1'b0;
      else if (run_go)
         done_q <= 1'b0;
      else if (chain_finish)
         done_q <= 1'b1;
   end

   assign sys_done_o = done_q;

endmodule

// File: rtl/decomp_seq_ctrl_chk.sv
module decomp_seq_ctrl_chk #(
   parameter int NUM_STAGES = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sys_start_i,
   input logic                  sys_done_o,
   input logic                  fifo_empty_i,
   input logic                  fifo_rd_o,
   input logic                  bank_a_we_o,
   input logic [NUM_STAGES-1:0] stage_start_o,
   input logic                  next_stage_o,
   input logic                  board_ready_i
);
   a_r4_read_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_o |-> !fifo_empty_i);

   a_r5_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stage_start_o));

   a_r5_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (|stage_start_o) |=> !(|stage_start_o));

   a_r6_quiet_during_load: assert property (@(posedge clk) disable iff (!rst_n)
      bank_a_we_o |-> (!next_stage_o && stage_start_o == '0));

   a_r7_handoff_held: assert property (@(posedge clk) disable iff (!rst_n)
      (next_stage_o && !board_ready_i) |=> next_stage_o);

   a_r9_done_held: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_done_o && !sys_start_i) |=> sys_done_o);

   a_r9_done_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sys_done_o |-> (!fifo_rd_o && !next_stage_o && stage_start_o == '0));

endmodule

bind decomp_seq_ctrl decomp_seq_ctrl_chk #(
   .NUM_STAGES (NUM_STAGES)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .sys_start_i   (sys_start_i),
   .sys_done_o    (sys_done_o),
   .fifo_empty_i  (fifo_empty_i),
   .fifo_rd_o     (fifo_rd_o),
   .bank_a_we_o   (bank_a_we_o),
   .stage_start_o (stage_start_o),
   .next_stage_o  (next_stage_o),
   .board_ready_i (board_ready_i)
);

// File: tb/decomp_seq_ctrl_tb_top.sv
module decomp_seq_ctrl_tb_top;
   localparam int DW = 16;
   localparam int AW = 10;
   localparam int NS = 5;

   typedef enum int {M_IDLE, M_LOAD, M_START, M_WAIT, M_HAND, M_DONE} mstate_e;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sys_start_i = 1'b0;
   logic          sys_done_o;
   logic          fifo_empty_i = 1'b1;
   logic [DW-1:0] fifo_data_i = '0;
   logic          fifo_rd_o;
   logic          bank_a_we_o;
   logic [AW-1:0] bank_a_addr_o;
   logic [DW-1:0] bank_a_wdata_o;
   logic [NS-1:0] stage_start_o;
   logic [NS-1:0] stage_done_i = '0;
   logic          next_stage_o;
   logic          board_ready_i = 1'b0;

   always #10 clk = ~clk;

   decomp_seq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .NUM_STAGES(NS)) dut_i (
      .clk(clk), .rst_n(rst_n), .sys_start_i(sys_start_i), .sys_done_o(sys_done_o),
      .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i), .fifo_rd_o(fifo_rd_o),
      .bank_a_we_o(bank_a_we_o), .bank_a_addr_o(bank_a_addr_o),
      .bank_a_wdata_o(bank_a_wdata_o), .stage_start_o(stage_start_o),
      .stage_done_i(stage_done_i), .next_stage_o(next_stage_o),
      .board_ready_i(board_ready_i)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // environment state
   logic [DW-1:0]     fifo_q[$];
   bit                pop_pend = 0;
   bit                stall_en = 0;
   bit                spur_en  = 0;
   logic [15:0]       lfsr = 16'hACE1;
   int                pend[NS];
   int                hcnt = -1;
   int                stage_lat = 2;
   int                host_lat = 1;
   logic [DW-1:0]     mem_a[int];
   int                wr_count = 0;

   // reference model state
   mstate_e m_st = M_IDLE;
   int      m_idx = 0;
   int      m_terms = 0;
   int      m_sel = 0;

   initial for (int g = 0; g < NS; g++) pend[g] = -1;

   always begin
      @(negedge clk);
      if (pop_pend && fifo_q.size() > 0) void'(fifo_q.pop_front());
      pop_pend = 0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fifo_empty_i = (fifo_q.size() == 0) || (stall_en && lfsr[0]);
      fifo_data_i  = (fifo_q.size() > 0) ? fifo_q[0] : 16'h5A5A;
      stage_done_i = '0;
      for (int g = 0; g < NS; g++) begin
         if (pend[g] > 0) pend[g]--;
         else if (pend[g] == 0) begin stage_done_i[g] = 1'b1; pend[g] = -1; end
         else if (spur_en && lfsr[g+2] && lfsr[g+8]) stage_done_i[g] = 1'b1;
      end
      board_ready_i = 1'b0;
      if (hcnt > 0) hcnt--;
      else if (hcnt == 0) begin board_ready_i = 1'b1; hcnt = -1; end
      else if (spur_en && lfsr[15] && lfsr[14] && lfsr[3]) board_ready_i = 1'b1;

      #5;
      begin
         bit             e_rd, e_we, e_next, e_done, last;
         logic [63:0]    e_start, e_addr, e_wd;
         e_rd = 0; e_we = 0; e_next = 0; e_done = 0; last = 0;
         e_start = '0; e_addr = '0; e_wd = '0;
         if (!rst_n) begin
            m_st = M_IDLE;
            chk("R1", "fifo_rd", 64'(fifo_rd_o), 0);
            chk("R1", "bank_we", 64'(bank_a_we_o), 0);
            chk("R1", "stage_start", 64'(stage_start_o), 0);
            chk("R1", "next_stage", 64'(next_stage_o), 0);
            chk("R1", "sys_done", 64'(sys_done_o), 0);
         end else begin
            e_done = (m_st == M_DONE);
            case (m_st)
               M_IDLE, M_DONE: if (sys_start_i) begin m_st = M_LOAD; m_idx = 0; end
               M_LOAD: if (!fifo_empty_i) begin
                  e_rd = 1; e_we = 1; e_addr = 64'(m_idx); e_wd = 64'(fifo_data_i);
                  if (m_idx == 1) m_terms = int'(fifo_data_i);
                  last = (m_idx == 1 && fifo_data_i == 0) ||
                         (m_idx >= 2 && m_idx == m_terms + 1);
                  if (last) begin m_st = M_START; m_sel = 0; end
                  else m_idx++;
               end
               M_START: begin e_start = 64'(1) << m_sel; m_st = M_WAIT; end
               M_WAIT: if (stage_done_i[m_sel])
                  m_st = (m_sel == NS - 1) ? M_DONE : M_HAND;
               M_HAND: begin
                  e_next = 1;
                  if (board_ready_i) begin m_sel++; m_st = M_START; end
               end
               default: m_st = M_IDLE;
            endcase
            chk("R4", "fifo_rd", 64'(fifo_rd_o), 64'(e_rd));
            chk("R4", "bank_we", 64'(bank_a_we_o), 64'(e_we));
            if (e_we) begin
               chk(e_addr < 2 ? "R2" : "R3", "bank_addr", 64'(bank_a_addr_o), e_addr);
               chk(e_addr < 2 ? "R2" : "R4", "bank_wdata", 64'(bank_a_wdata_o), e_wd);
            end
            chk(e_start == 1 ? "R6" : (spur_en ? "R8" : "R5"), "stage_start",
                64'(stage_start_o), e_start);
            chk("R7", "next_stage", 64'(next_stage_o), 64'(e_next));
            chk("R9", "sys_done", 64'(sys_done_o), 64'(e_done));
         end
         pop_pend = fifo_rd_o;
         if (bank_a_we_o) begin
            mem_a[int'(bank_a_addr_o)] = bank_a_wdata_o;
            wr_count++;
         end
         for (int g = 0; g < NS; g++)
            if (stage_start_o[g]) pend[g] = stage_lat;
         if (next_stage_o && hcnt < 0 && !board_ready_i) hcnt = host_lat;
      end
   end

   task automatic run_case(int n, int m, bit stall, bit spur, bit late_terms);
      logic [DW-1:0] words[$];
      int            t;
      words.push_back(DW'(n));
      words.push_back(DW'(m));
      for (int c = 1; c <= m; c++) words.push_back(DW'(c * 16'h0131) ^ DW'(n << 8));
      mem_a.delete();
      wr_count = 0;
      @(negedge clk);
      stall_en = stall;
      spur_en  = spur;
      if (late_terms) begin
         fifo_q.push_back(words[0]);
         fifo_q.push_back(words[1]);
      end else begin
         foreach (words[i]) fifo_q.push_back(words[i]);
      end
      sys_start_i = 1'b1;
      @(negedge clk);
      sys_start_i = 1'b0;
      if (late_terms) begin
         repeat (6) @(negedge clk);
         for (int i = 2; i < words.size(); i++) fifo_q.push_back(words[i]);
      end
      if (spur) begin
         // R9: start requests mid-run must be ignored
         for (int k = 0; k < 4; k++) begin
            repeat (7) @(negedge clk);
            sys_start_i = 1'b1;
            @(negedge clk);
            sys_start_i = 1'b0;
         end
      end
      t = 0;
      while (!sys_done_o && t < 3000) begin @(negedge clk); t++; end
      chk("R9", "run reached done", 64'(t < 3000), 1);
      repeat (5) @(negedge clk);
      stall_en = 0;
      spur_en  = 0;
      chk("R3", "write count", 64'(wr_count), 64'(m + 2));
      chk("R2", "addr0 variable count", mem_a.exists(0) ? 64'(mem_a[0]) : 64'hBAD, 64'(n));
      chk("R2", "addr1 term count", mem_a.exists(1) ? 64'(mem_a[1]) : 64'hBAD, 64'(m));
      for (int c = 1; c <= m; c++)
         chk("R3", "term word", mem_a.exists(c + 1) ? 64'(mem_a[c + 1]) : 64'hBAD,
             64'(words[c + 1]));
      chk("R4", "fifo drained", 64'(fifo_q.size()), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      stage_lat = 2; host_lat = 1;
      run_case(4, 3, 0, 0, 0);
      stage_lat = 0; host_lat = 0;
      run_case(3, 1, 1, 0, 1);
      run_case(2, 0, 0, 0, 0);
      stage_lat = 4; host_lat = 3;
      run_case(5, 8, 1, 1, 0);
      stage_lat = 1; host_lat = 2;
      run_case(6, 2, 1, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule